// File: doc/BRIEF.md
# Sequential-Scan Content-Addressable Lookup Engine

This block answers "which addresses hold this value?" for a table of 2^M words of N bits each. The table sits in a plain memory with a narrow write side and a wide read side. A search does not compare every word at once. It walks the memory one line at a time, where each line holds K consecutive words. K equality comparators check the words of a line against the search key in the same cycle, and their results are placed into a 2^M-bit unencoded match vector.

Software-side logic fills the table through an encoded-address write port, one word per cycle. A lookup is launched with a one-cycle start strobe that carries the key. While the scan runs, `busy` stays high. A one-cycle `done` pulse then marks the point where the match vector is complete, and the vector holds its value until the next accepted start. Any write or start request made while the engine is busy is dropped. Every word carries a valid flag that reset clears, so slots that were never written cannot report a hit. Ternary matching and priority encoding are not part of the block.

Top module: `seqcam`

## Requirements
- R1: After reset `busy`, `done` and every bit of `match_vec` are 0, and every word is marked invalid.
- R2: A write request while not busy stores `wr_data` at word `wr_addr` and marks that word valid from the next cycle on.
- R3: A start request while not busy latches `srch_key`, clears `match_vec` to 0 and raises `busy` in the next cycle.
- R4: When `done` is high, bit i of `match_vec` is 1 exactly when word i is valid and holds the latched key. Bit i belongs to the word at address i (memory line i/K, lane i mod K).
- R5: A word that has never been written since reset never sets its match bit, whatever the key.
- R6: `done` goes high exactly 2^M/K + 1 cycles after the clock edge that accepts the start: one cycle per line, plus one cycle of read latency. `busy` is high in every cycle in between.
- R7: `done` is high for a single cycle, and `busy` is low in that cycle.
- R8: A write request while busy has no effect on the stored table.
- R9: A start request while busy has no effect: the running scan keeps its key and its timing.
- R10: Once `done` has pulsed, `match_vec` keeps its value until the next accepted start, including across later idle writes.
- R11: The same value stored at several addresses sets all of their bits. Rewriting an address replaces its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | M | Encoded word address for the write |
| wr_data | input | N | Word value to store |
| srch_start | input | 1 | Start strobe for a lookup |
| srch_key | input | N | Value to search for, sampled with the strobe |
| busy | output | 1 | High while a scan is in progress |
| done | output | 1 | One-cycle pulse when the match vector is complete |
| match_vec | output | 2^M | Unencoded hit vector, bit i for address i |

## Verification
A wrong line counter or lane mapping shows up as a match bit at the wrong address, or as a missing bit. The bench sees this at the `done` pulse of the very first search that has a hit in the affected line. A stuck valid flag shows up as a hit on an unwritten address during the search just after reset. An error in the pipeline alignment moves `done` off its fixed latency of 2^M/K + 1 cycles, or leaves the last line's bits unset, and both are caught on every search. Any leak of requests into a busy engine shows up as altered bits in later searches of the same key.

// File: rtl/seqcam.sv
module seqcam #(
  parameter int M = 5,
  parameter int N = 7,
  parameter int K = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [M-1:0]      wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic              srch_start,
  input  logic [N-1:0]      srch_key,
  output logic              busy,
  output logic              done,
  output logic [2**M-1:0]   match_vec
);
  localparam int DEPTH   = 2**M;
  localparam int LINES   = DEPTH / K;
  localparam int LINE_AW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int CNT_W   = LINE_AW + 2;

  logic [N-1:0]       mem [DEPTH];
  logic [DEPTH-1:0]   valid;
  logic [N-1:0]       key;
  logic               issuing, cmp_en, cmp_last;
  logic [LINE_AW-1:0] rd_line, cmp_line;
  logic [N-1:0]       rd_q [K];
  logic [K-1:0]       hits;

  assign busy = issuing | cmp_en;

  wire wr_ok    = wr_en & ~busy;
  wire start_ok = srch_start & ~busy;
  wire rd_last  = rd_line == LINE_AW'(LINES - 1);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else if (wr_ok) valid[wr_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < K; k++) rd_q[k] <= mem[int'(rd_line) * K + k];
  end

  always_comb begin
    for (int k = 0; k < K; k++)
      hits[k] = valid[int'(cmp_line) * K + k] && (rd_q[k] == key);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing  <= 1'b0;
      cmp_en   <= 1'b0;
      cmp_last <= 1'b0;
      rd_line  <= '0;
      cmp_line <= '0;
      key      <= '0;
      done     <= 1'b0;
      match_vec <= '0;
    end else begin
      done     <= cmp_en & cmp_last;
      cmp_en   <= issuing;
      cmp_last <= issuing & rd_last;
      cmp_line <= rd_line;
      if (start_ok) begin
        issuing   <= 1'b1;
        rd_line   <= '0;
        key       <= srch_key;
        match_vec <= '0;
      end else if (issuing) begin
        rd_line <= rd_line + 1'b1;
        if (rd_last) issuing <= 1'b0;
      end
      if (cmp_en)
        for (int k = 0; k < K; k++) match_vec[int'(cmp_line) * K + k] <= hits[k];
    end
  end

  logic [CNT_W-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (start_ok) lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 1'b1;
  end

  // R1: unwritten words are invalid, so they never appear in the vector (also R5)
  a_r5_no_invalid_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~valid) == '0);

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_start && !busy) |=> (busy && match_vec == '0));

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_cnt == CNT_W'(LINES + 1));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !srch_start) |=> $stable(match_vec));

  a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(valid));

  a_r9_key_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(key));
endmodule

// File: tb/test_seqcam.sv
module test_seqcam;
  localparam int M = 5, N = 7, K = 4;
  localparam int DEPTH = 2**M;
  localparam int LINES = DEPTH / K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [M-1:0] wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic srch_start = 1'b0;
  logic [N-1:0] srch_key = '0;
  logic busy, done;
  logic [DEPTH-1:0] match_vec;

  seqcam #(.M(M), .N(N), .K(K)) i_seqcam (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .srch_start(srch_start), .srch_key(srch_key), .busy(busy), .done(done),
    .match_vec(match_vec));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [N-1:0] mdl_d [DEPTH];
  logic [DEPTH-1:0] mdl_v = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DEPTH-1:0] exp_vec(input logic [N-1:0] k);
    logic [DEPTH-1:0] v = '0;
    for (int a = 0; a < DEPTH; a++) if (mdl_v[a] && mdl_d[a] == k) v[a] = 1'b1;
    return v;
  endfunction

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = M'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl_v[a] = 1'b1; mdl_d[a] = d;
  endtask

  // mode 0: plain; 1: write during busy (R8); 2: start during busy (R9)
  task automatic search(input logic [N-1:0] k, input int mode, input string tag);
    logic [DEPTH-1:0] e;
    e = exp_vec(k);
    @(negedge clk);
    srch_start = 1'b1; srch_key = k;
    @(negedge clk);
    srch_start = 1'b0;
    chk({tag, " R3 busy after start"}, 64'(busy), 64'd1);
    chk({tag, " R3 vector cleared"}, 64'(match_vec), 64'd0);
    for (int i = 1; i <= LINES + 1; i++) begin
      if (i == 2 && mode == 1) begin wr_en = 1'b1; wr_addr = 8; wr_data = k; end
      if (i == 2 && mode == 2) begin srch_start = 1'b1; srch_key = k ^ 7'h0C; end
      @(negedge clk);
      wr_en = 1'b0; srch_start = 1'b0;
      if (i <= LINES) begin
        chk({tag, " R6 busy during scan"}, 64'(busy), 64'd1);
        chk({tag, " R6 no early done"}, 64'(done), 64'd0);
      end
    end
    chk({tag, " R6 done on time"}, 64'(done), 64'd1);
    chk({tag, " R7 busy low at done"}, 64'(busy), 64'd0);
    chk({tag, " R4 match vector"}, 64'(match_vec), 64'(e));
    @(negedge clk);
    chk({tag, " R7 done single cycle"}, 64'(done), 64'd0);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mdl_d[a] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 match", 64'(match_vec), 64'd0);
    rst_n = 1'b1;
    search(7'h00, 0, "R5 empty key0");
    search(7'h7F, 0, "R5 empty key7f");

    for (int a = 0; a < DEPTH; a++) if (a % 7 != 6) wr(a, N'((a * 3) % 10));
    search(7'h03, 0, "R2 R11 dup key3");
    wr(5, 7'h1A);
    search(7'h1A, 0, "R11 rewrite new");
    search(7'h05, 0, "R11 rewrite old");
    for (int k = 0; k < 10; k++) search(N'(k), 0, "R4 sweep");
    search(7'h08, 0, "R5 unwritten slots");

    search(7'h33, 1, "R8 write busy");
    search(7'h33, 0, "R8 after");
    search(7'h06, 2, "R9 start busy");

    search(7'h04, 0, "R10 base");
    begin
      logic [DEPTH-1:0] held;
      held = match_vec;
      wr(3, 7'h04);
      repeat (4) @(negedge clk);
      chk("R10 held after idle write", 64'(match_vec), 64'(held));
    end
    search(7'h04, 0, "R2 R10 new search");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule